// File: doc/BRIEF.md
# Register space address decoder

This block sits behind a slave bus port and turns each bus address into the selects that steer the access. Bit 24 picks one of two state sets, which stand for two independent hardware contexts. Bit 23 splits the map into a frame-buffer half and a register half. Inside the register half, the unit field and a few sub-fields pick one of the following targets: a boot ROM, a command unit with four register partitions, one of five draw units, a cursor/colour unit or a DAC port. The top three bits of a 28-bit bus address are not decoded.

Every strobe is answered with an acknowledge exactly one clock later. This holds for holes, for reserved codes and for writes to read-only locations. Such accesses simply produce no enable. The result is held in registers for one cycle and is presented together with the acknowledge. It consists of a one-hot chip select, per-draw-unit write enables, a read-data mux select, the command partition and the ROM byte offset. Outside the acknowledge cycle every result output is zero. A write with draw code 111 enables all five draw units at once. A read with that code is treated as a hole.

The request interface is a plain strobe/acknowledge pair rather than valid/ready. The block never stalls, so there is no back-pressure. A strobe may be raised in consecutive cycles, and each one gets its own acknowledge in the following cycle.

Top module: `regspace_decoder`

## Requirements
- R1: `bus_ack` is high in exactly the cycle after each cycle in which `bus_strobe` is high, and low after every cycle without a strobe; this holds for every address, including holes.
- R2: Address bits 27:25 have no effect on any output.
- R3: In the acknowledge cycle, `set_sel` equals address bit 24 and `fb_sel` equals bit 23. With bit 23 set, `chip_sel` and `draw_we` are zero, and `rd_sel` is 10 on a read and 0 on a write.
- R4: `chip_sel` is one-hot or zero. Its bit positions are [0] boot ROM, [1] command unit, [2] draw units, [3] cursor/colour unit, [4] DAC.
- R5: With register space and bits 22:21 = 11, bit 12 = 0 selects the cursor/colour unit (`rd_sel` 8 on read) and bit 12 = 1 selects the DAC (`rd_sel` 9 on read). Both are selected for reads and for writes.
- R6: With bits 22:21 = 10 and draw code (bits 11:9) n from 0 to 4, the access selects the draw units. A write sets only `draw_we[n]`. A read sets `rd_sel` to 3+n and leaves `draw_we` zero.
- R7: Draw code 111 on a write selects the draw units and sets all five `draw_we` bits. On a read, draw code 111 is a hole: no select, and `rd_sel` is 0.
- R8: Draw codes 101 and 110 are holes for reads and for writes: no `chip_sel`, no `draw_we`, and `rd_sel` 0.
- R9: With bits 22:21 = 01, the command unit is selected for reads and writes, with `cmd_part` = {bit 24, bit 11}. `cmd_part` is zero for every other target. `rd_sel` is 2 on a read.
- R10: A read with bits 22:21 = 00 selects the boot ROM in either state set, whatever bits 20:16 hold. `rd_sel` is 1 and `rom_ofs` equals address bits 15:0. `rom_ofs` is zero for every other access.
- R11: A write with bits 22:21 = 00 is acknowledged but asserts no `chip_sel`, no `draw_we` and `rd_sel` 0, because the ROM is read-only.
- R12: Outside the acknowledge cycle, `set_sel`, `fb_sel`, `chip_sel`, `draw_we`, `rd_sel`, `cmd_part` and `rom_ofs` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_strobe | input | 1 | Access request, one cycle per access |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 28 | Bus byte address |
| bus_ack | output | 1 | Acknowledge, one cycle after the strobe |
| set_sel | output | 1 | State set of the acknowledged access |
| fb_sel | output | 1 | Frame-buffer space selected |
| chip_sel | output | 5 | One-hot target select |
| draw_we | output | 5 | Per-draw-unit write enable |
| rd_sel | output | 4 | Read-data mux select |
| cmd_part | output | 2 | Command unit partition {state set, clock domain} |
| rom_ofs | output | 16 | Boot ROM byte offset |

## Verification
Several properties are checked by assertions on every cycle. These are the one-cycle acknowledge timing, the one-hot chip select, the quiet outputs between acknowledges and the tracking of the state-set bit. They also cover the rule that a frame-buffer access never raises a chip select and the rule that a write enable is either one unit or all five. Only the bench scenarios can show that each unit code, sub-code and direction reaches the exact target the requirements name. The same holds for the ROM offset aliasing and for the fact that reserved codes, read broadcasts and ROM writes enable nothing.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  localparam int CHIP_N     = 5;
  localparam int CS_ROM     = 0;
  localparam int CS_CMD     = 1;
  localparam int CS_DRAW    = 2;
  localparam int CS_CUR     = 3;
  localparam int CS_DAC     = 4;
  localparam int RD_W       = 4;
  localparam int ROM_OFS_W  = 16;
  localparam int DCODE_W    = 3;

  localparam logic [RD_W-1:0] RD_NONE  = 4'd0;
  localparam logic [RD_W-1:0] RD_ROM   = 4'd1;
  localparam logic [RD_W-1:0] RD_CMD   = 4'd2;
  localparam logic [RD_W-1:0] RD_DRAW0 = 4'd3;
  localparam logic [RD_W-1:0] RD_CUR   = 4'd8;
  localparam logic [RD_W-1:0] RD_DAC   = 4'd9;
  localparam logic [RD_W-1:0] RD_FB    = 4'd10;

  typedef struct packed {
    logic                 set;
    logic                 fb;
    logic [1:0]           unit;
    logic                 sub;
    logic [DCODE_W-1:0]   code;
    logic                 dom;
    logic [ROM_OFS_W-1:0] ofs;
  } fields_t;
endpackage

// File: rtl/rsd_field_split.sv
module rsd_field_split
  import rsd_pkg::*;
#(
  parameter int ADDR_W    = 28,
  parameter int SET_BIT   = 24,
  parameter int SPACE_BIT = 23,
  parameter int UNIT_LSB  = 21,
  parameter int SUB_BIT   = 12,
  parameter int CODE_LSB  = 9,
  parameter int DOM_BIT   = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output fields_t           fld
);
  always_comb begin
    fld.set  = addr[SET_BIT];
    fld.fb   = addr[SPACE_BIT];
    fld.unit = addr[UNIT_LSB +: 2];
    fld.sub  = addr[SUB_BIT];
    fld.code = addr[CODE_LSB +: DCODE_W];
    fld.dom  = addr[DOM_BIT];
    fld.ofs  = addr[ROM_OFS_W-1:0];
  end
endmodule

// File: rtl/rsd_draw_sel.sv
module rsd_draw_sel
  import rsd_pkg::*;
#(
  parameter int NUM_DRAW = 5
) (
  input  logic                en,
  input  logic                rnw,
  input  logic [DCODE_W-1:0]  code,
  output logic                hit,
  output logic [NUM_DRAW-1:0] we,
  output logic [RD_W-1:0]     rd
);
  localparam logic [DCODE_W-1:0] BCAST = {DCODE_W{1'b1}};

  logic [NUM_DRAW-1:0] match;
  logic                bcast_wr;

  assign bcast_wr = en && !rnw && (code == BCAST);

  for (genvar i = 0; i < NUM_DRAW; i++) begin : g_unit
    assign match[i] = en && (code == DCODE_W'(i));
    assign we[i]    = (match[i] && !rnw) || bcast_wr;
  end

  assign hit = (|match) || bcast_wr;

  always_comb begin
    rd = RD_NONE;
    for (int i = 0; i < NUM_DRAW; i++) begin
      if (match[i] && rnw) rd = RD_DRAW0 + RD_W'(i);
    end
  end
endmodule

// File: rtl/rsd_resp_reg.sv
module rsd_resp_reg #(
  parameter int W = 34
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] d,
  output logic         ack,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0;
      q   <= '0;
    end else begin
      ack <= strobe;
      q   <= strobe ? d : '0;
    end
  end
endmodule

// File: rtl/regspace_decoder.sv
module regspace_decoder
  import rsd_pkg::*;
#(
  parameter int ADDR_W   = 28,
  parameter int NUM_DRAW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_strobe,
  input  logic                 bus_rnw,
  input  logic [ADDR_W-1:0]    bus_addr,
  output logic                 bus_ack,
  output logic                 set_sel,
  output logic                 fb_sel,
  output logic [CHIP_N-1:0]    chip_sel,
  output logic [NUM_DRAW-1:0]  draw_we,
  output logic [RD_W-1:0]      rd_sel,
  output logic [1:0]           cmd_part,
  output logic [ROM_OFS_W-1:0] rom_ofs
);
  localparam int RESP_W = 2 + CHIP_N + NUM_DRAW + RD_W + 2 + ROM_OFS_W;

  fields_t                fld;
  logic                   draw_en;
  logic                   draw_hit;
  logic [NUM_DRAW-1:0]    draw_we_d;
  logic [RD_W-1:0]        draw_rd;
  logic [CHIP_N-1:0]      cs_d;
  logic [RD_W-1:0]        rd_d;
  logic [1:0]             part_d;
  logic [ROM_OFS_W-1:0]   ofs_d;
  logic [RESP_W-1:0]      resp_d;
  logic [RESP_W-1:0]      resp_q;

  rsd_field_split #(.ADDR_W(ADDR_W)) u_split (
    .addr (bus_addr),
    .fld  (fld)
  );

  assign draw_en = !fld.fb && (fld.unit == 2'b10);

  rsd_draw_sel #(.NUM_DRAW(NUM_DRAW)) u_draw (
    .en   (draw_en),
    .rnw  (bus_rnw),
    .code (fld.code),
    .hit  (draw_hit),
    .we   (draw_we_d),
    .rd   (draw_rd)
  );

  always_comb begin
    cs_d   = '0;
    rd_d   = RD_NONE;
    part_d = '0;
    ofs_d  = '0;
    if (fld.fb) begin
      rd_d = bus_rnw ? RD_FB : RD_NONE;
    end else begin
      case (fld.unit)
        2'b00: begin
          if (bus_rnw) begin
            cs_d[CS_ROM] = 1'b1;
            rd_d         = RD_ROM;
            ofs_d        = fld.ofs;
          end
        end
        2'b01: begin
          cs_d[CS_CMD] = 1'b1;
          part_d       = {fld.set, fld.dom};
          if (bus_rnw) rd_d = RD_CMD;
        end
        2'b10: begin
          cs_d[CS_DRAW] = draw_hit;
          rd_d          = draw_rd;
        end
        default: begin
          if (fld.sub) begin
            cs_d[CS_DAC] = 1'b1;
            if (bus_rnw) rd_d = RD_DAC;
          end else begin
            cs_d[CS_CUR] = 1'b1;
            if (bus_rnw) rd_d = RD_CUR;
          end
        end
      endcase
    end
  end

  assign resp_d = {fld.set, fld.fb, cs_d, draw_we_d, rd_d, part_d, ofs_d};

  rsd_resp_reg #(.W(RESP_W)) u_resp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (bus_strobe),
    .d      (resp_d),
    .ack    (bus_ack),
    .q      (resp_q)
  );

  assign {set_sel, fb_sel, chip_sel, draw_we, rd_sel, cmd_part, rom_ofs} = resp_q;
endmodule

// File: rtl/rsd_checker.sv
module rsd_checker #(
  parameter int ADDR_W   = 28,
  parameter int NUM_DRAW = 5,
  parameter int SET_BIT  = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_strobe,
  input logic                bus_rnw,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_ack,
  input logic                set_sel,
  input logic                fb_sel,
  input logic [4:0]          chip_sel,
  input logic [NUM_DRAW-1:0] draw_we,
  input logic [3:0]          rd_sel
);
  // R1
  ack_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |=> bus_ack);
  // R1
  no_spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe |=> !bus_ack);
  // R4
  chip_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chip_sel));
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack |-> (chip_sel == '0 && draw_we == '0 && rd_sel == '0 && !set_sel && !fb_sel));
  // R3
  set_tracks_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |=> (set_sel == $past(bus_addr[SET_BIT])));
  // R3
  fb_no_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_sel |-> (chip_sel == '0 && draw_we == '0));
  // R7
  we_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (draw_we != '0) |-> (($countones(draw_we) == 1 || draw_we == '1) && chip_sel[2]));
  // R6
  read_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && bus_rnw) |=> (draw_we == '0));
endmodule

bind regspace_decoder rsd_checker #(.ADDR_W(ADDR_W), .NUM_DRAW(NUM_DRAW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_strobe (bus_strobe),
  .bus_rnw    (bus_rnw),
  .bus_addr   (bus_addr),
  .bus_ack    (bus_ack),
  .set_sel    (set_sel),
  .fb_sel     (fb_sel),
  .chip_sel   (chip_sel),
  .draw_we    (draw_we),
  .rd_sel     (rd_sel)
);

// File: tb/sim_regspace_decoder.sv
module sim_regspace_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int RESP_W = 2 + 5 + 5 + 4 + 2 + 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_strobe = 1'b0;
  logic        bus_rnw = 1'b0;
  logic [27:0] bus_addr = '0;
  logic        bus_ack;
  logic        set_sel, fb_sel;
  logic [4:0]  chip_sel, draw_we;
  logic [3:0]  rd_sel;
  logic [1:0]  cmd_part;
  logic [15:0] rom_ofs;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regspace_decoder u0 (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_rnw(bus_rnw),
    .bus_addr(bus_addr), .bus_ack(bus_ack), .set_sel(set_sel), .fb_sel(fb_sel),
    .chip_sel(chip_sel), .draw_we(draw_we), .rd_sel(rd_sel),
    .cmd_part(cmd_part), .rom_ofs(rom_ofs)
  );

  function automatic logic [RESP_W-1:0] expect_of(logic [27:0] a, logic rnw);
    logic [4:0] cs = '0, we = '0;
    logic [3:0] rd = 4'd0;
    logic [1:0] part = '0;
    logic [15:0] ofs = '0;
    logic [2:0] code = a[11:9];
    if (a[23]) begin
      rd = rnw ? 4'd10 : 4'd0;
    end else begin
      case (a[22:21])
        2'b00: if (rnw) begin cs = 5'b00001; rd = 4'd1; ofs = a[15:0]; end
        2'b01: begin cs = 5'b00010; part = {a[24], a[11]}; if (rnw) rd = 4'd2; end
        2'b10: begin
          if (code <= 3'd4) begin
            cs = 5'b00100;
            if (rnw) rd = 4'd3 + {1'b0, code};
            else     we = 5'(1 << code);
          end else if (code == 3'd7 && !rnw) begin
            cs = 5'b00100; we = 5'b11111;
          end
        end
        default: begin
          if (a[12]) begin cs = 5'b10000; if (rnw) rd = 4'd9; end
          else       begin cs = 5'b01000; if (rnw) rd = 4'd8; end
        end
      endcase
    end
    return {a[24], a[23], cs, we, rd, part, ofs};
  endfunction

  function automatic string tag_of(logic [27:0] a, logic rnw);
    if (a[23]) return "R3";
    case (a[22:21])
      2'b00: return rnw ? "R10" : "R11";
      2'b01: return "R9";
      2'b10: return (a[11:9] <= 3'd4) ? "R6" : (a[11:9] == 3'd7 ? "R7" : "R8");
      default: return "R5";
    endcase
  endfunction

  function automatic logic [RESP_W-1:0] observed();
    return {set_sel, fb_sel, chip_sel, draw_we, rd_sel, cmd_part, rom_ofs};
  endfunction

  task automatic check(string req, logic [RESP_W-1:0] act, logic [RESP_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access; returns with the clock at the negedge of the ack cycle.
  task automatic access(logic [27:0] a, logic rnw, output logic [RESP_W-1:0] got);
    bus_addr = a; bus_rnw = rnw; bus_strobe = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_strobe = 1'b0;
    // R1: ack present in the cycle after the strobe
    check("R1", {{(RESP_W-1){1'b0}}, bus_ack}, {{(RESP_W-1){1'b0}}, 1'b1});
    got = observed();
    // R4: chip select one-hot or zero
    check("R4", {{(RESP_W-1){1'b0}}, ($countones(chip_sel) <= 1)}, {{(RESP_W-1){1'b0}}, 1'b1});
  endtask

  task automatic run_one(logic [27:0] a, logic rnw);
    logic [RESP_W-1:0] got;
    access(a, rnw, got);
    check(tag_of(a, rnw), got, expect_of(a, rnw));
  endtask

  task automatic idle_check();
    @(posedge clk); @(negedge clk);
    // R1 and R12: no ack and quiet outputs without a strobe
    check("R1", {{(RESP_W-1){1'b0}}, bus_ack}, '0);
    check("R12", observed(), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [RESP_W-1:0] g1, g2;
    int seed;
    seed = 32'h1d5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // reset state (R12)
    check("R12", {bus_ack, observed()} , '0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_check();

    // directed corners
    run_one(28'h0000000, 1'b1);          // R10 ROM set 0
    run_one(28'h11F1234, 1'b1);          // R10 ROM set 1, bits 20:16 set
    run_one(28'h0001234, 1'b0);          // R11 ROM write
    run_one(28'h0200000, 1'b0);          // R9 partition 00
    run_one(28'h1200800, 1'b1);          // R9 partition 11
    run_one(28'h0400800, 1'b1);          // R6 unit 4 read
    run_one(28'h0400400, 1'b0);          // R6 unit 2 write
    run_one(28'h0400E00, 1'b0);          // R7 broadcast write
    run_one(28'h0400E00, 1'b1);          // R7 broadcast read = hole
    run_one(28'h0400A00, 1'b0);          // R8 code 101
    run_one(28'h0400C00, 1'b1);          // R8 code 110
    run_one(28'h0600000, 1'b1);          // R5 cursor
    run_one(28'h0601000, 1'b0);          // R5 DAC write
    run_one(28'h0800000, 1'b1);          // R3 frame buffer read
    run_one(28'h1800000, 1'b0);          // R3 frame buffer write
    idle_check();

    // R2: top bits ignored
    for (int k = 0; k < 16; k++) begin
      logic [27:0] a;
      logic rnw;
      a = 28'($urandom) & 28'h1FFFFFF;
      rnw = 1'($urandom);
      access(a, rnw, g1);
      access(a | {3'($urandom | 1), 25'h0}, rnw, g2);
      check("R2", g2, g1);
    end

    // constrained random, back-to-back or with gaps
    for (int k = 0; k < 600; k++) begin
      logic [27:0] a;
      logic rnw;
      a = 28'($urandom);
      if ($urandom % 4 != 0) a[23] = 1'b0;
      rnw = 1'($urandom);
      run_one(a, rnw);
      if ($urandom % 3 == 0) idle_check();
    end
    idle_check();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule